// File: doc/BRIEF.md
# Interval Memory Activity Monitor

This block watches the command stream and power state of a memory controller with two pseudo channels. It counts activity over a window of memory clocks that software programs. For each pseudo channel it keeps a separate count of each of the eight command kinds, and it keeps separate counts of read-to-write turnarounds, reorder-queue age-limit hits and read-modify-write cycles. Two more counters, shared by both channels, count the cycles spent in power-down and the cycles spent in self-refresh. All counters are 32 bits wide.

When a window closes, the live counts are copied into snapshot registers and a completion flag is raised. The flag clears itself when software reads it. Software can start one window only, or let windows run back to back without a gap. The snapshots, the control fields and the flag are all read through a simple register interface. On that interface a write takes effect at the next clock edge, and read data follows the address combinationally.

Top module: `activityWindowMon`

## Requirements
- R1: After reset the completion flag, the repeat enable, the interval field and every snapshot read as 0, and no window is running.
- R2: A window lasts exactly N clocks, where N is the interval field. It counts the events presented in the N clock cycles that follow the cycle of the starting write. An interval of 0 gives a one-clock window.
- R3: Writing 1 to bit 0 of address 1 while the repeat enable is 0 and no window is running starts one window. When that window ends, counting stops and the snapshots keep their values.
- R4: Writing 1 to bit 0 of address 0 (the repeat enable) while idle starts windows that follow each other with no gap, and the snapshots are refreshed at the end of each one. If the repeat enable reads 0 in the last cycle of a window, no further window follows.
- R5: The completion flag (address 3, bit 0) is set at the end of every window. Any read of address 3 clears it. If a window ends in the same cycle as that read, the flag stays set.
- R6: Each channel counts command strobes by kind, using the 3-bit kind code: 0 write, 1 write with auto-precharge, 2 read, 3 read with auto-precharge, 4 refresh, 5 activate, 6 single-bank precharge, 7 all-bank precharge. Channel c's snapshot of kind k is at address 16*(c+1)+k.
- R7: The cycles in which the power-down indicator is high are counted and read at address 4. The cycles in which the self-refresh indicator is high are counted and read at address 5.
- R8: Each channel remembers whether its most recent read or write command was a read. A write-kind command (code 0 or 1) that follows a read-kind command (code 2 or 3) adds one to the channel's turnaround count, at address 16*(c+1)+8. Refresh, activate and precharge commands do not change the remembered direction.
- R9: Each channel counts its age-limit pulses, read at address 16*(c+1)+9, and its read-modify-write pulses, read at address 16*(c+1)+10.
- R10: Live counts start from zero in every window. An event in the last cycle of a window is included in that window's snapshot and not in the next one.
- R11: Address 0 bit 0 (repeat enable) and address 2 (interval, 32 bits) read back the last value written. Address 1 and addresses that are not mapped read as 0.
- R12: A write to the single-start control has no effect while a window is running or while the repeat enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (clears the flag at address 3) |
| regAddr | input | 6 | Register word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| cmdValid | input | 2 | Command strobe per pseudo channel |
| cmdKind | input | 6 | 3-bit command kind code per channel (channel 0 in bits 2:0) |
| pdState | input | 1 | Memory is in power-down this cycle |
| srState | input | 1 | Memory is in self-refresh this cycle |
| ageHit | input | 2 | Reorder-queue age-limit pulse per channel |
| rmwHit | input | 2 | Read-modify-write pulse per channel |
| doneFlag | output | 1 | Completion flag |

## Verification
Register writes, window starts and the event counts of a cycle all take effect at the next clock edge. A snapshot and the completion flag change at the edge that closes the window, which is N edges after the starting write. Read data is combinational, so the value for the address being driven is due in the same cycle and reflects every edge up to then. The bench advances its behavioural model at each rising edge, using the same inputs as the design. It compares the read data with the model at the following falling edge, before the next stimulus is applied, so every result is sampled exactly one edge after the stimulus that caused it.

// File: rtl/awmPkg.sv
package awmPkg;
  typedef enum logic [2:0] {
    CMD_WR   = 3'd0,
    CMD_WRA  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_RDA  = 3'd3,
    CMD_REF  = 3'd4,
    CMD_ACT  = 3'd5,
    CMD_PRE  = 3'd6,
    CMD_PREA = 3'd7
  } cmdKind_e;

  localparam int NUM_KINDS = 8;
  localparam int K_TURN    = 8;
  localparam int K_AGE     = 9;
  localparam int K_RMW     = 10;
  localparam int PER_CH    = 11;

  localparam int A_REPEAT   = 0;
  localparam int A_SINGLE   = 1;
  localparam int A_INTERVAL = 2;
  localparam int A_DONE     = 3;
  localparam int A_PDCYC    = 4;
  localparam int A_SRCYC    = 5;

  typedef struct packed {
    logic countEn;
    logic clearLive;
    logic capture;
  } winStrb_t;
endpackage

// File: rtl/awmControl.sv
module awmControl
  import awmPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output winStrb_t          strb,
  output logic              repeatEn,
  output logic [DATA_W-1:0] intervalQ,
  output logic              doneFlag,
  output logic              running
);
  logic [DATA_W-1:0] remain;
  logic [DATA_W-1:0] lenM1;
  logic wrRepeat, wrSingle, wrInterval, rdDone, startNow, lastCycle;

  assign wrRepeat   = regWrEn && (regAddr == ADDR_W'(A_REPEAT));
  assign wrSingle   = regWrEn && (regAddr == ADDR_W'(A_SINGLE)) && regWrData[0];
  assign wrInterval = regWrEn && (regAddr == ADDR_W'(A_INTERVAL));
  assign rdDone     = regRdEn && (regAddr == ADDR_W'(A_DONE));

  // R3, R4, R12: a window starts only from idle
  assign startNow  = !running && ((wrRepeat && regWrData[0]) || (wrSingle && !repeatEn));
  assign lastCycle = running && (remain == '0);
  // R2: an interval of zero acts as one clock
  assign lenM1     = (intervalQ == '0) ? '0 : intervalQ - DATA_W'(1);

  always_comb begin
    strb.countEn   = running;
    strb.capture   = lastCycle;
    strb.clearLive = startNow || lastCycle;  // R10
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      repeatEn  <= 1'b0;
      intervalQ <= '0;
      running   <= 1'b0;
      remain    <= '0;
      doneFlag  <= 1'b0;
    end else begin
      if (wrRepeat)   repeatEn  <= regWrData[0];
      if (wrInterval) intervalQ <= regWrData;
      if (startNow) begin
        running <= 1'b1;
        remain  <= lenM1;
      end else if (lastCycle) begin
        running <= repeatEn;              // R4: repeat continues, single stops
        remain  <= lenM1;
      end else if (running) begin
        remain  <= remain - DATA_W'(1);
      end
      if (lastCycle)   doneFlag <= 1'b1;  // R5: set wins over clear
      else if (rdDone) doneFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/awmDatapath.sv
module awmDatapath
  import awmPkg::*;
#(
  parameter  int NUM_CH  = 2,
  parameter  int CNT_W   = 32,
  localparam int NUM_EVT = NUM_CH * PER_CH + 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  winStrb_t               strb,
  input  logic [NUM_CH-1:0]      cmdValid,
  input  logic [NUM_CH-1:0][2:0] cmdKind,
  input  logic                   pdState,
  input  logic                   srState,
  input  logic [NUM_CH-1:0]      ageHit,
  input  logic [NUM_CH-1:0]      rmwHit,
  output logic [CNT_W-1:0]       snap [NUM_EVT]
);
  logic [NUM_EVT-1:0] evt;
  logic [NUM_CH-1:0]  lastRd;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic isRd, isWr;
    assign isRd = cmdValid[c] && ((cmdKind[c] == CMD_RD) || (cmdKind[c] == CMD_RDA));
    assign isWr = cmdValid[c] && ((cmdKind[c] == CMD_WR) || (cmdKind[c] == CMD_WRA));

    // R6: one event line per command kind
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
      assign evt[c*PER_CH + k] = cmdValid[c] && (cmdKind[c] == 3'(k));
    end

    // R8: direction memory changes on data commands only
    always_ff @(posedge clk) begin
      if (!rstN)     lastRd[c] <= 1'b0;
      else if (isRd) lastRd[c] <= 1'b1;
      else if (isWr) lastRd[c] <= 1'b0;
    end

    assign evt[c*PER_CH + K_TURN] = isWr && lastRd[c];
    assign evt[c*PER_CH + K_AGE]  = ageHit[c];   // R9
    assign evt[c*PER_CH + K_RMW]  = rmwHit[c];   // R9
  end

  // R7: shared state-cycle counters
  assign evt[NUM_CH*PER_CH]     = pdState;
  assign evt[NUM_CH*PER_CH + 1] = srState;

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_cnt
    logic [CNT_W-1:0] live, sum;
    assign sum = live + CNT_W'(strb.countEn && evt[e]);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        live    <= '0;
        snap[e] <= '0;
      end else begin
        live <= strb.clearLive ? '0 : sum;      // R10
        if (strb.capture) snap[e] <= sum;       // R10: last-cycle event included
      end
    end
  end
endmodule

// File: rtl/activityWindowMon.sv
module activityWindowMon
  import awmPkg::*;
#(
  parameter  int NUM_CH = 2,
  parameter  int DATA_W = 32,
  localparam int ADDR_W = $clog2(16 * (NUM_CH + 1)),
  localparam int NUM_EVT = NUM_CH * PER_CH + 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic                   regRdEn,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [DATA_W-1:0]      regWrData,
  output logic [DATA_W-1:0]      regRdData,
  input  logic [NUM_CH-1:0]      cmdValid,
  input  logic [NUM_CH-1:0][2:0] cmdKind,
  input  logic                   pdState,
  input  logic                   srState,
  input  logic [NUM_CH-1:0]      ageHit,
  input  logic [NUM_CH-1:0]      rmwHit,
  output logic                   doneFlag
);
  winStrb_t          strb;
  logic              repeatEn, running;
  logic [DATA_W-1:0] intervalQ;
  logic [DATA_W-1:0] snap [NUM_EVT];
  int                rdHi, rdLo;

  awmControl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .strb(strb),
    .repeatEn(repeatEn), .intervalQ(intervalQ), .doneFlag(doneFlag),
    .running(running)
  );

  awmDatapath #(.NUM_CH(NUM_CH), .CNT_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdValid(cmdValid),
    .cmdKind(cmdKind), .pdState(pdState), .srState(srState),
    .ageHit(ageHit), .rmwHit(rmwHit), .snap(snap)
  );

  // R11: read map
  always_comb begin
    regRdData = '0;
    rdHi = int'(regAddr[ADDR_W-1:4]);
    rdLo = int'(regAddr[3:0]);
    if (rdHi == 0) begin
      case (regAddr[3:0])
        4'(A_REPEAT):   regRdData = DATA_W'(repeatEn);
        4'(A_INTERVAL): regRdData = intervalQ;
        4'(A_DONE):     regRdData = DATA_W'(doneFlag);
        4'(A_PDCYC):    regRdData = snap[NUM_CH*PER_CH];
        4'(A_SRCYC):    regRdData = snap[NUM_CH*PER_CH + 1];
        default:        regRdData = '0;
      endcase
    end else if (rdHi <= NUM_CH && rdLo < PER_CH) begin
      regRdData = snap[(rdHi - 1) * PER_CH + rdLo];
    end
  end
endmodule

// File: rtl/awmChecker.sv
module awmChecker
  import awmPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input winStrb_t          strb,
  input logic              running,
  input logic              repeatEn,
  input logic              doneFlag,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] snap0
);
  p_done_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> doneFlag);

  p_done_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_W'(A_DONE) && !strb.capture) |=> !doneFlag);

  p_single_stop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !repeatEn) |=> !running);

  p_repeat_go_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && repeatEn) |=> running);

  p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(snap0));
endmodule

bind activityWindowMon awmChecker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .strb(strb), .running(running),
  .repeatEn(repeatEn), .doneFlag(doneFlag), .regRdEn(regRdEn),
  .regAddr(regAddr), .snap0(snap[0])
);

// File: tb/activityWindowMon_test.sv
`timescale 1ns/1ps
module activityWindowMon_test;
  localparam int NEV = 2 * 11 + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [5:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [1:0] cmdValid = '0;
  logic [1:0][2:0] cmdKind = '0;
  logic pdState = 1'b0, srState = 1'b0;
  logic [1:0] ageHit = '0, rmwHit = '0;
  logic doneFlag;

  int checks = 0, errors = 0;
  string scen = "R1";

  // behavioural model
  logic [31:0] mLive [NEV];
  logic [31:0] mSnap [NEV];
  logic [31:0] mIv, mEl, mLen;
  bit mRun, mRep, mDone;
  bit mLastRd [2];

  always #2.5 clk = ~clk;

  activityWindowMon uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .cmdValid(cmdValid), .cmdKind(cmdKind), .pdState(pdState),
    .srState(srState), .ageHit(ageHit), .rmwHit(rmwHit), .doneFlag(doneFlag)
  );

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL R2 watchdog expired: actual=hung expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic modelStep();
    bit ev [NEV];
    bit oRun = mRun, oRep = mRep;
    logic [31:0] oIv = mIv;
    bit start, last;
    for (int c = 0; c < 2; c++) begin
      bit rd = cmdValid[c] && (cmdKind[c] == 3'd2 || cmdKind[c] == 3'd3);
      bit wr = cmdValid[c] && (cmdKind[c] == 3'd0 || cmdKind[c] == 3'd1);
      for (int k = 0; k < 8; k++) ev[c*11 + k] = cmdValid[c] && (cmdKind[c] == 3'(k));
      ev[c*11 + 8]  = wr && mLastRd[c];
      ev[c*11 + 9]  = ageHit[c];
      ev[c*11 + 10] = rmwHit[c];
      if (rd) mLastRd[c] = 1;
      else if (wr) mLastRd[c] = 0;
    end
    ev[22] = pdState;
    ev[23] = srState;
    start = !oRun && ((regWrEn && regAddr == 0 && regWrData[0]) ||
                      (regWrEn && regAddr == 1 && regWrData[0] && !oRep));
    last = oRun && (mEl + 1 == mLen);
    if (oRun) begin
      for (int e = 0; e < NEV; e++) if (ev[e]) mLive[e] = mLive[e] + 1;
      mEl = mEl + 1;
    end
    if (last) begin
      for (int e = 0; e < NEV; e++) begin mSnap[e] = mLive[e]; mLive[e] = 0; end
      mDone = 1; mEl = 0; mLen = (oIv == 0) ? 1 : oIv; mRun = oRep;
    end else if (regRdEn && regAddr == 3) mDone = 0;
    if (start) begin
      for (int e = 0; e < NEV; e++) mLive[e] = 0;
      mEl = 0; mLen = (oIv == 0) ? 1 : oIv; mRun = 1;
    end
    if (regWrEn && regAddr == 0) mRep = regWrData[0];
    if (regWrEn && regAddr == 2) mIv = regWrData;
  endtask

  function automatic logic [31:0] expRd(int a);
    int hi = a / 16, lo = a % 16;
    if (hi == 0) begin
      case (lo)
        0: return 32'(mRep);
        2: return mIv;
        3: return 32'(mDone);
        4: return mSnap[22];
        5: return mSnap[23];
        default: return 0;
      endcase
    end
    if (hi <= 2 && lo < 11) return mSnap[(hi-1)*11 + lo];
    return 0;
  endfunction

  function automatic string tagFor(int a);
    int lo = a % 16;
    if (a < 3) return "R11";
    if (a == 3) return "R5";
    if (a < 16) return "R7";
    if (lo < 8) return "R6";
    if (lo == 8) return "R8";
    return "R9";
  endfunction

  task automatic cyc();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    checks++;
    if (regRdData !== expRd(int'(regAddr))) begin
      errors++;
      $display("FAIL %s/%s addr=%0d actual=%0d expected=%0d", scen,
               tagFor(int'(regAddr)), regAddr, regRdData, expRd(int'(regAddr)));
    end
  endtask

  function automatic logic [5:0] randAddr();
    int r = int'($urandom % 27);
    if (r < 5) begin
      case (r) 0: return 6'd0; 1: return 6'd2; 2: return 6'd3; 3: return 6'd4; default: return 6'd5; endcase
    end
    r = r - 5;
    if (r < 11) return 6'(16 + r);
    return 6'(32 + r - 11);
  endfunction

  task automatic writeReg(int a, logic [31:0] d);
    regWrEn = 1; regRdEn = 0; regAddr = 6'(a); regWrData = d;
    cyc();
    regWrEn = 0;
  endtask

  task automatic run(int n, bit traffic);
    for (int i = 0; i < n; i++) begin
      if (traffic) begin
        for (int c = 0; c < 2; c++) begin
          cmdValid[c] = ($urandom % 3) != 0;
          cmdKind[c]  = 3'($urandom % 8);
          ageHit[c]   = ($urandom % 5) == 0;
          rmwHit[c]   = ($urandom % 4) == 0;
        end
        pdState = ($urandom % 3) == 0;
        srState = ($urandom % 4) == 0;
      end else begin
        cmdValid = '0; ageHit = '0; rmwHit = '0; pdState = 0; srState = 0;
      end
      regAddr = randAddr();
      regRdEn = ($urandom % 2) == 0;
      cyc();
    end
  endtask

  initial begin
    for (int e = 0; e < NEV; e++) begin mLive[e] = 0; mSnap[e] = 0; end
    mIv = 0; mEl = 0; mLen = 1; mRun = 0; mRep = 0; mDone = 0;
    mLastRd[0] = 0; mLastRd[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1: reset state of every mapped address, no traffic
    scen = "R1";
    for (int a = 0; a < 48; a++) begin
      regAddr = 6'(a); regRdEn = 0;
      cyc();
    end
    scen = "R3";
    writeReg(2, 20);
    writeReg(1, 1);
    run(25, 1);
    run(60, 0);
    scen = "R12";
    writeReg(1, 1);
    run(5, 1);
    writeReg(1, 1);
    run(30, 1);
    run(30, 0);
    scen = "R4";
    writeReg(2, 7);
    writeReg(0, 1);
    run(60, 1);
    writeReg(1, 1);
    run(10, 1);
    writeReg(0, 0);
    run(30, 1);
    run(30, 0);
    scen = "R10";
    writeReg(2, 3);
    writeReg(0, 1);
    run(40, 1);
    writeReg(0, 0);
    run(20, 0);
    scen = "R2";
    writeReg(2, 0);
    writeReg(0, 1);
    run(30, 1);
    writeReg(0, 0);
    run(10, 1);
    run(40, 0);
    scen = "R11";
    writeReg(2, 32'hA5A5_0001);
    for (int a = 0; a < 16; a++) begin
      regAddr = 6'(a); regRdEn = 0;
      cyc();
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule